// File: doc/BRIEF.md
# Multi-Register Stack Push Sequencer

This block carries out a push of several registers onto a full-descending stack inside a simple processor datapath. On a start pulse it takes a 16-bit compressed instruction word, a condition-pass flag and the current stack pointer. It decodes which registers to save and works out the lowest address of the new stack frame from the number of selected registers. It then reads each selected register through a single register-file read port and issues one 32-bit word store per accepted handshake on a valid/ready memory write interface.

Stores go out in ascending register order: the lowest-numbered register goes to the lowest address. Once the last store has been accepted, the block writes the lowered stack pointer back in the same cycle as its one-cycle done pulse. An instruction whose condition fails finishes as a no-op. An empty register list or a word that is not this instruction finishes with an illegal flag. A stack pointer that is not word-aligned finishes with an alignment flag. None of these three cases stores anything or changes the stack pointer.

Top module: `spush_engine`

## Requirements
- R1: An instruction is recognised only when bits [15:12] are 1011, bit 11 is 0 and bits [10:9] are 10. A condition-passing word that fails this match ends with `illegal` high during `done`, with no stores and no `sp_we`.
- R2: The register list has R0..R7 taken from instruction bits [7:0] (bit i selects Ri) and R14 taken from instruction bit 8. No other register is ever stored.
- R3: A matching word whose list is empty ends with `illegal` high during `done`, with no stores and no `sp_we`.
- R4: The first store address is the sampled stack pointer minus 4 times the number of selected registers.
- R5: Stores occur in ascending register number. Each store drives `rf_idx` with the register number and `mem_wdata` with `rf_data`, and the address rises by 4 after every accepted store.
- R6: In the cycle after the last store is accepted, `done` and `sp_we` are high together for exactly one cycle. `sp_wdata` then equals the sampled stack pointer minus 4 times the register count.
- R7: If the sampled stack pointer has bits [1:0] not equal to 0 on an otherwise valid push, the operation ends with `align_fault` high during `done`, with no stores and no `sp_we`.
- R8: With `cond_pass` low at start, the operation ends with `done` the next cycle and no stores, no `sp_we` and no fault flag. The condition test ranks above the illegal check, which ranks above the alignment check.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_wdata` and `rf_idx` hold steady and `mem_valid` stays high.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. A start pulse while busy is ignored and does not begin a second operation.
- R11: The stack pointer and instruction are sampled only when start is accepted. Later changes to `sp_in` or `instr` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| instr | input | 16 | Compressed instruction word |
| cond_pass | input | 1 | Condition check result for the instruction |
| sp_in | input | 32 | Current stack pointer value |
| rf_idx | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data for `rf_idx` |
| mem_valid | output | 1 | Store request valid |
| mem_addr | output | 32 | Store word address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the store this cycle |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 32 | New stack pointer value |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal instruction, valid with `done` |
| align_fault | output | 1 | Misaligned stack pointer, valid with `done` |
| busy | output | 1 | Operation in progress |

## Verification
The bench goes after several corner cases, each with a known failure mode:
- A list holding only R14, or one that mixes R14 with R7: a wrong expansion stores R8 or puts R14 at the wrong slot.
- A full list of nine registers with long memory back-pressure: a sequencer that moves on without the handshake skips or repeats a register, and an address step tied to the clock rather than to acceptance drifts.
- An empty list, a non-matching word, a misaligned stack pointer and a failed condition, alone and in combination: a wrong priority or a missing guard shows up as a stray store, a stray stack pointer write or the wrong flag.
- Start pulses and stack pointer changes during a running operation: a design that samples too late, or re-arms while busy, produces wrong addresses or a second operation.

// File: rtl/spush_pkg.sv
package spush_pkg;
  localparam int LIST_W     = 16;
  localparam int IDX_W      = $clog2(LIST_W);
  localparam int CNT_W      = IDX_W + 1;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = 4;
  localparam int LOW_REGS   = 8;
  localparam int LINK_IDX   = 14;
  localparam int INSTR_W    = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STORE  = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic              opcode_ok;
    logic [LIST_W-1:0] reglist;
    logic [CNT_W-1:0]  count;
  } decode_t;

  function automatic logic [CNT_W-1:0] list_weight(input logic [LIST_W-1:0] l);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < LIST_W; i++) n = n + CNT_W'(l[i]);
    return n;
  endfunction

  function automatic logic [ADDR_W-1:0] frame_base(input logic [ADDR_W-1:0] sp,
                                                   input logic [CNT_W-1:0] n);
    return sp - (ADDR_W'(n) * ADDR_W'(WORD_BYTES));
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(WORD_BYTES);
  endfunction

  function automatic logic word_aligned(input logic [ADDR_W-1:0] a);
    return (a % ADDR_W'(WORD_BYTES)) == '0;
  endfunction
endpackage

// File: rtl/spush_decode.sv
module spush_decode
  import spush_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decode_t            dec
);
  logic [LIST_W-1:0] list_w;

  generate
    for (genvar i = 0; i < LIST_W; i++) begin : g_list
      if (i < LOW_REGS) begin : g_low
        assign list_w[i] = instr[i];
      end else if (i == LINK_IDX) begin : g_link
        assign list_w[i] = instr[LOW_REGS];
      end else begin : g_zero
        assign list_w[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    dec.opcode_ok = (instr[15:12] == 4'b1011) && !instr[11] && (instr[10:9] == 2'b10);
    dec.reglist   = list_w;
    dec.count     = list_weight(list_w);
  end
endmodule

// File: rtl/spush_pick.sv
module spush_pick
  import spush_pkg::*;
(
  input  logic [LIST_W-1:0] pending,
  output logic [LIST_W-1:0] grant,
  output logic [IDX_W-1:0]  idx
);
  logic [LIST_W:0] seen;

  assign seen[0] = 1'b0;
  generate
    for (genvar i = 0; i < LIST_W; i++) begin : g_prio
      assign grant[i]  = pending[i] & ~seen[i];
      assign seen[i+1] = seen[i] | pending[i];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < LIST_W; i++)
      if (grant[i]) idx = idx | IDX_W'(i);
  end
endmodule

// File: rtl/spush_frame.sv
module spush_frame
  import spush_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sp_next
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      sp_next <= '0;
    end else if (load) begin
      addr    <= base;
      sp_next <= base;
    end else if (advance) begin
      addr    <= step_addr(addr);
    end
  end

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (addr == $past(addr) + ADDR_W'(WORD_BYTES)));

  // R6
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sp_next));
endmodule

// File: rtl/spush_engine.sv
module spush_engine
  import spush_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic               cond_pass,
  input  logic [ADDR_W-1:0]  sp_in,
  output logic [IDX_W-1:0]   rf_idx,
  input  logic [DATA_W-1:0]  rf_data,
  output logic               mem_valid,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ready,
  output logic               sp_we,
  output logic [ADDR_W-1:0]  sp_wdata,
  output logic               done,
  output logic               illegal,
  output logic               align_fault,
  output logic               busy
);
  seq_state_e        state_q;
  decode_t           dec;
  logic [LIST_W-1:0] pending_q;
  logic [LIST_W-1:0] grant;
  logic [LIST_W-1:0] pending_after;
  logic              ill_q, alg_q, wb_q;

  // named internal events
  logic accept, go_store, is_illegal, is_misaligned;
  logic store_fire, last_store;

  spush_decode u_decode (.instr(instr), .dec(dec));

  spush_pick u_pick (.pending(pending_q), .grant(grant), .idx(rf_idx));

  spush_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (go_store),
    .base    (frame_base(sp_in, dec.count)),
    .advance (store_fire),
    .addr    (mem_addr),
    .sp_next (sp_wdata)
  );

  assign accept        = start && (state_q == ST_IDLE);
  assign is_illegal    = !dec.opcode_ok || (dec.count == '0);
  assign is_misaligned = !word_aligned(sp_in);
  assign go_store      = accept && cond_pass && !is_illegal && !is_misaligned;

  assign mem_valid     = (state_q == ST_STORE);
  assign mem_wdata     = rf_data;
  assign store_fire    = mem_valid && mem_ready;
  assign pending_after = pending_q & ~grant;
  assign last_store    = store_fire && (pending_after == '0);

  assign done        = (state_q == ST_FINISH);
  assign sp_we       = done && wb_q;
  assign illegal     = done && ill_q;
  assign align_fault = done && alg_q;
  assign busy        = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      ill_q     <= 1'b0;
      alg_q     <= 1'b0;
      wb_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ill_q <= cond_pass && is_illegal;
            alg_q <= cond_pass && !is_illegal && is_misaligned;
            wb_q  <= go_store;
            if (go_store) begin
              pending_q <= dec.reglist;
              state_q   <= ST_STORE;
            end else begin
              state_q   <= ST_FINISH;
            end
          end
        end
        ST_STORE: begin
          if (store_fire) begin
            pending_q <= pending_after;
            if (last_store) state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          state_q <= ST_IDLE;
          ill_q   <= 1'b0;
          alg_q   <= 1'b0;
          wb_q    <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  hold_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(rf_idx)));

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5
  ascend_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && !last_store) |=> (rf_idx > $past(rf_idx)));

  // R6
  wb_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_store |=> (sp_we && done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || align_fault) |-> !sp_we);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && start) |=> (state_q != ST_IDLE));
endmodule

// File: tb/spush_engine_bench.sv
module spush_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        cond_pass = 1'b0;
  logic [31:0] sp_in = '0;
  logic [3:0]  rf_idx;
  logic [31:0] rf_data;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic        sp_we;
  logic [31:0] sp_wdata;
  logic        done, illegal, align_fault, busy;
  logic [31:0] salt = 32'h0;

  int checks = 0;
  int fails  = 0;
  int seed_dummy;

  always #2 clk = ~clk;

  function automatic logic [31:0] regval(input logic [3:0] k, input logic [31:0] s);
    return 32'hC0DE_0000 ^ ({28'h0, k} * 32'h0101_0101) ^ s;
  endfunction

  assign rf_data = regval(rf_idx, salt);

  spush_engine u_spush_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .cond_pass(cond_pass),
    .sp_in(sp_in), .rf_idx(rf_idx), .rf_data(rf_data), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .sp_we(sp_we),
    .sp_wdata(sp_wdata), .done(done), .illegal(illegal), .align_fault(align_fault),
    .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_list(input logic [15:0] w);
    logic [15:0] l;
    l = {8'h00, w[7:0]};
    l[14] = w[8];
    return l;
  endfunction

  function automatic int weight(input logic [15:0] l);
    int n = 0;
    for (int i = 0; i < 16; i++) if (l[i]) n++;
    return n;
  endfunction

  task automatic run_op(input logic [15:0] w, input bit cp, input logic [31:0] sp,
                        input int ready_pct, input bit poke);
    logic [15:0] lst, left;
    int cnt, n, cyc, k;
    bit match, exp_ill, exp_alg, exp_store, seen_done, stall_prev;
    logic [31:0] base, prev_addr;
    lst       = exp_list(w);
    cnt       = weight(lst);
    match     = (w[15:9] == 7'b1011010);
    exp_ill   = cp && (!match || cnt == 0);
    exp_alg   = cp && !exp_ill && (sp[1:0] != 2'b00);
    exp_store = cp && !exp_ill && !exp_alg;
    base      = sp - 32'(4 * cnt);
    left      = lst;
    n = 0; seen_done = 0; stall_prev = 0; prev_addr = '0;
    salt = $urandom;
    @(negedge clk);
    start = 1'b1; instr = w; cond_pass = cp; sp_in = sp;
    for (cyc = 0; cyc < 400 && !seen_done; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
        // R11: inputs changing mid-operation must not matter; R10: restart ignored
        sp_in = $urandom;
        instr = $urandom;
        cond_pass = 1'b1;
        start = (cyc == 1);
      end
      mem_ready = (($urandom % 100) < ready_pct);
      #1;
      if (stall_prev)
        check(mem_valid && mem_addr == prev_addr, "R9", "held store", mem_addr, prev_addr);
      if (mem_valid) begin
        check(exp_store && left != 0, "R2", "unexpected store", {28'h0, rf_idx}, 32'h0);
        check(busy, "R10", "busy during store", {31'h0, busy}, 32'h1);
        if (mem_ready && left != 0) begin
          k = 0;
          while (!left[k]) k++;
          check(rf_idx == 4'(k), "R5", "store order index", {28'h0, rf_idx}, 32'(k));
          check(mem_addr == base + 32'(4 * n), (n == 0) ? "R4" : "R5", "store address",
                mem_addr, base + 32'(4 * n));
          check(mem_wdata == regval(4'(k), salt), "R5", "store data", mem_wdata,
                regval(4'(k), salt));
          left[k] = 1'b0;
          n++;
        end
      end
      stall_prev = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      if (done) begin
        seen_done = 1;
        check(illegal == exp_ill, exp_ill || !match ? "R1" : "R3", "illegal flag",
              {31'h0, illegal}, {31'h0, exp_ill});
        check(align_fault == exp_alg, "R7", "align flag", {31'h0, align_fault},
              {31'h0, exp_alg});
        check(sp_we == exp_store, cp ? "R6" : "R8", "sp write enable", {31'h0, sp_we},
              {31'h0, exp_store});
        check(n == (exp_store ? cnt : 0), "R2", "store count", 32'(n),
              32'(exp_store ? cnt : 0));
        if (exp_store)
          check(sp_wdata == base, "R6", "new stack pointer", sp_wdata, base);
        if (!cp)
          check(cyc == 0, "R8", "no-op latency", 32'(cyc), 32'h0);
      end
    end
    check(seen_done, "R6", "done seen", {31'h0, seen_done}, 32'h1);
    start = 1'b0; mem_ready = 1'b1;
    @(negedge clk); #1;
    check(!done && !busy && !mem_valid, "R10", "idle after done (single pulse)",
          {29'h0, done, busy, mem_valid}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    #1;
    check(!mem_valid && !done && !sp_we && !busy, "R10", "reset state",
          {28'h0, mem_valid, done, sp_we, busy}, 32'h0);
    rst_n = 1'b1;
    // R2: single low register, R14 alone, R14 with R7, full list
    run_op(16'hB401, 1'b1, 32'h0000_1000, 100, 1'b0);
    run_op(16'hB500, 1'b1, 32'h0000_2000, 100, 1'b0);
    run_op(16'hB580, 1'b1, 32'h0000_2004, 50,  1'b0);
    run_op(16'hB5FF, 1'b1, 32'h8000_0000, 20,  1'b0);
    // R3: empty list
    run_op(16'hB400, 1'b1, 32'h0000_1000, 100, 1'b0);
    // R1: wrong bit 11, wrong bits [10:9], wrong top nibble
    run_op(16'hBC0F, 1'b1, 32'h0000_1000, 100, 1'b0);
    run_op(16'hB20F, 1'b1, 32'h0000_1000, 100, 1'b0);
    run_op(16'hA40F, 1'b1, 32'h0000_1000, 100, 1'b0);
    // R7: misaligned, and illegal beats misaligned
    run_op(16'hB40F, 1'b1, 32'h0000_1002, 100, 1'b0);
    run_op(16'hB400, 1'b1, 32'h0000_1001, 100, 1'b0);
    // R8: condition fail ranks above illegal and misaligned
    run_op(16'hB5FF, 1'b0, 32'h0000_1000, 100, 1'b0);
    run_op(16'hB400, 1'b0, 32'h0000_1003, 100, 1'b0);
    // R10 R11: pokes while busy, heavy back-pressure
    run_op(16'hB5AA, 1'b1, 32'h0000_4000, 30, 1'b1);
    run_op(16'hB40C, 1'b1, 32'h0000_0010, 60, 1'b1);
    // wrap below address zero
    run_op(16'hB403, 1'b1, 32'h0000_0004, 100, 1'b0);
    for (int t = 0; t < 60; t++) begin
      logic [15:0] w;
      logic [31:0] sp;
      w  = {7'b1011010, 9'($urandom)};
      if (($urandom % 8) == 0) w = 16'($urandom);
      sp = $urandom;
      if (($urandom % 4) != 0) sp[1:0] = 2'b00;
      run_op(w, (($urandom % 8) != 0), sp, 25 + int'($urandom % 76), (($urandom % 3) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule